// File: doc/BRIEF.md
# SMBus Block-Transfer Configuration Register Target

This block is an SMBus target that lets a host read and write a bank of 22 byte-wide configuration registers. Every transfer is a block transaction. A write carries a starting register index, a byte count and then the data bytes. A read first sets the index in a short write, then uses a repeated START with the read address. The target answers with a byte count and then streams register contents from that index upward. The register index steps by one after every data byte.

SCL and SDA are sampled by a fast system clock through synchronizers. The target pulls SDA low through an enable output; the pad and the pull-up sit outside the block. Three strap pins choose one of eight bus addresses.

The bank holds several kinds of register:
- Writable control registers, whose contents drive the outputs.
- Read-only registers that mirror live pin levels.
- A fixed identification register.
- A writable byte-count register.
- Reserved locations.

Two control bits are combined with two input pins to produce mode selects. A 0 from either the bit or the pin forces the mode.

Top module: `smb_cfg_target`

## Requirements
- R1: The 8-bit write address is 0xD0 + 2·`addr_strap_i` and the read address is that value + 1; both are ACKed. Any other address byte is NACKed, and the target then drives nothing on SDA until the next START or STOP.
- R2: A block write (START, write address, index N, count X, data bytes, STOP) ACKs every byte and stores the X data bytes at N, N+1, … N+X-1 in order.
- R3: Data bytes sent beyond the count X are still ACKed but are not stored.
- R4: A block read (START, write address, index N, repeated START, read address) returns first the count register value, then the bytes at N, N+1, … for as long as the host ACKs. After the host's NACK the target releases SDA.
- R5: Index 8 is the byte-count register. It is read/write, resets to 0x07, and its value is the first byte of every block read.
- R6: Index 7 is read-only and reads 0x11: revision ID 1 in bits 7:4 and vendor ID 1 in bits 3:0. Writes to it have no effect.
- R7: Indexes 3 to 6 are read-only and mirror `pin_rb_i` live: index 3 = bits 7:0, index 4 = bits 15:8, index 5 = bits 23:16, index 6 = bits 31:24. Writes to them have no effect.
- R8: `hi_bw_sel_o` is 1 when bit 7 of index 2 is 0 or `bw_pin_i` is 0. `bypass_sel_o` is 1 when bit 6 of index 2 is 0 or `byp_strap_i` is 0.
- R9: After reset, indexes 0, 1 and 2 hold 0xFF, index 8 holds 0x07, and indexes 9 to 19 hold 0x00. `regs_o` carries the read value of index i in bits 8i+7:8i.
- R10: Indexes 20 and 21 are reserved, and indexes 22 and above do not exist. Writes to all of them are ACKed and discarded, and reads of them return 0x00.
- R11: START and STOP are recognised only while SCL is high. A STOP aborts any transfer and leaves SDA released, and bytes already stored are kept.
- R12: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SMBus clock line level |
| sda_i | input | 1 | SMBus data line level |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| addr_strap_i | input | 3 | Low address bits from the strap pins |
| bw_pin_i | input | 1 | Bandwidth pin; 0 forces the high-bandwidth mode |
| byp_strap_i | input | 1 | Bypass strap; 0 forces the bypass mode |
| pin_rb_i | input | 32 | Live pin levels shown at indexes 3 to 6 |
| regs_o | output | 176 | Read image of indexes 0 to 21, byte i at bits 8i+7:8i |
| hi_bw_sel_o | output | 1 | High-bandwidth mode select |
| bypass_sel_o | output | 1 | Bypass mode select |

## Verification
The assertions take for granted that each SCL high phase and each low phase lasts longer than the synchronizer latency of about three system clocks. They also assume the host changes SDA only while SCL is low, except when it makes a START or a STOP. The bench drives every half bit period as eight system clocks and changes SDA only in the low phase. Random block writes with random index, count and overrun are mixed with directed cases: wrong address, read-only, reserved and out-of-range targets, and aborting STOPs.

// File: rtl/smb_cfg_pkg.sv
// Package: shared types of the SMBus configuration target.
// Assumes: register kinds are fixed at elaboration from index parameters.
package smb_cfg_pkg;

    typedef enum logic [1:0] {
        RK_RW   = 2'd0,
        RK_PIN  = 2'd1,
        RK_ID   = 2'd2,
        RK_RSVD = 2'd3
    } reg_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RX     = 3'd1,
        ST_RX_ACK = 3'd2,
        ST_TX     = 3'd3,
        ST_TX_ACK = 3'd4
    } link_state_e;

    typedef enum logic [2:0] {
        PH_ADDR  = 3'd0,
        PH_INDEX = 3'd1,
        PH_COUNT = 3'd2,
        PH_WDATA = 3'd3,
        PH_RD    = 3'd4
    } link_phase_e;

    // Classify a register index into its storage kind.
    function automatic reg_kind_e kind_of(int idx, int rb_first, int rb_num,
                                          int id_idx, int rsvd_first);
        if (idx >= rb_first && idx < rb_first + rb_num) return RK_PIN;
        if (idx == id_idx)                              return RK_ID;
        if (idx >= rsvd_first)                          return RK_RSVD;
        return RK_RW;
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
// Module: two-line synchronizer and bus event detector.
// Synchronizes SCL and SDA into clk and flags SCL edges and START/STOP.
// Assumes: clk is several times faster than SCL; lines idle high.
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_d;
    logic              sda_d;

    // Synchronizer chains plus one history flop per line, idle-high reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_d  <= scl_sh[STAGES-1];
            sda_d  <= sda_sh[STAGES-1];
        end
    end

    // Event decode: edges of SCL, SDA edges while SCL stays high.
    always_comb begin
        scl_lvl   = scl_sh[STAGES-1];
        sda_lvl   = sda_sh[STAGES-1];
        scl_rise  = scl_lvl & ~scl_d;
        scl_fall  = ~scl_lvl & scl_d;
        start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
        stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;
    end

    // R11: a START and a STOP can never be flagged together.
    p_start_stop_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_det && stop_det));

endmodule

// File: rtl/smb_cfg_bank.sv
// Module: configuration register bank.
// Holds writable registers, mirrors pins, returns a fixed ID, zeroes
// reserved and absent indexes. One write port, one combinational read port.
// Assumes: at most one write per clock, index may exceed the bank size.
module smb_cfg_bank
    import smb_cfg_pkg::*;
#(
    parameter int          NREGS      = 22,
    parameter int          IDX_W      = 8,
    parameter int          RB_FIRST   = 3,
    parameter int          RB_NUM     = 4,
    parameter int          ID_IDX     = 7,
    parameter int          CNT_IDX    = 8,
    parameter int          RSVD_FIRST = 20,
    parameter int          ONES_LAST  = 2,
    parameter logic [7:0]  CNT_RST    = 8'h07,
    parameter logic [3:0]  REV_ID     = 4'h1,
    parameter logic [3:0]  VEN_ID     = 4'h1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [7:0]            rd_data,
    input  logic [8*RB_NUM-1:0]   pin_rb_i,
    output logic [8*NREGS-1:0]    image_o,
    output logic [7:0]            count_o
);
    logic [7:0]       img [NREGS];
    logic [NREGS-1:0] wr_hit;

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        localparam reg_kind_e K = kind_of(g, RB_FIRST, RB_NUM, ID_IDX, RSVD_FIRST);
        if (K == RK_RW) begin : g_rw
            localparam logic [7:0] RST_V = (g <= ONES_LAST) ? 8'hFF :
                                           (g == CNT_IDX)   ? CNT_RST : 8'h00;
            logic [7:0] q;
            assign wr_hit[g] = wr_en && (wr_idx == IDX_W'(g));
            // Storage flop for one writable register.
            always_ff @(posedge clk) begin
                if (!rst_n)         q <= RST_V;
                else if (wr_hit[g]) q <= wr_data;
            end
            assign img[g] = q;
        end else if (K == RK_PIN) begin : g_pin
            assign wr_hit[g] = 1'b0;
            assign img[g]    = pin_rb_i[8*(g-RB_FIRST) +: 8];
        end else if (K == RK_ID) begin : g_id
            assign wr_hit[g] = 1'b0;
            assign img[g]    = {REV_ID, VEN_ID};
        end else begin : g_rsvd
            assign wr_hit[g] = 1'b0;
            assign img[g]    = 8'h00;
        end
        assign image_o[8*g +: 8] = img[g];
    end

    // Read mux: absent indexes read as zero.
    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NREGS; i++) begin
            if (rd_idx == IDX_W'(i)) rd_data = img[i];
        end
    end

    assign count_o = img[CNT_IDX];

    // R2: a write strobe lands on at most one register.
    p_one_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_hit));

    // R5: the count register only changes when written at its index.
    p_count_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_idx == IDX_W'(CNT_IDX)) |=> $stable(count_o));

endmodule

// File: rtl/smb_cfg_link.sv
// Module: SMBus block-protocol engine.
// Shifts bytes in on SCL rise, drives ACK and read data after SCL fall,
// decodes address/index/count/data phases, walks the register pointer.
// Assumes: inputs come from smb_line_sync; host keeps SDA stable while SCL high.
module smb_cfg_link
    import smb_cfg_pkg::*;
#(
    parameter int          STRAP_W   = 3,
    parameter int          IDX_W     = 8,
    parameter logic [6:0]  ADDR_BASE = 7'h68
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_lvl,
    input  logic               sda_lvl,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [7:0]         rd_data,
    input  logic [7:0]         count_val,
    output logic               sda_oe_o,
    output logic               wr_en_o,
    output logic [IDX_W-1:0]   wr_idx_o,
    output logic [7:0]         wr_data_o,
    output logic [IDX_W-1:0]   rd_idx_o
);
    link_state_e      st;
    link_phase_e      ph;
    logic [3:0]       bitcnt;
    logic [7:0]       shreg;
    logic [7:0]       txsh;
    logic [IDX_W-1:0] ptr;
    logic [7:0]       wleft;
    logic             is_read;
    logic             addr_hit;

    assign addr_hit = (shreg[7:1] == (ADDR_BASE | 7'(strap_i)));
    assign rd_idx_o = ptr;

    // Protocol sequencer: one bus event handled per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            ph        <= PH_ADDR;
            bitcnt    <= '0;
            shreg     <= '0;
            txsh      <= '0;
            ptr       <= '0;
            wleft     <= '0;
            is_read   <= 1'b0;
            sda_oe_o  <= 1'b0;
            wr_en_o   <= 1'b0;
            wr_idx_o  <= '0;
            wr_data_o <= '0;
        end else begin
            wr_en_o <= 1'b0;
            if (start_det) begin
                st       <= ST_RX;
                ph       <= PH_ADDR;
                bitcnt   <= '0;
                sda_oe_o <= 1'b0;
            end else if (stop_det) begin
                st       <= ST_IDLE;
                sda_oe_o <= 1'b0;
            end else begin
                case (st)
                    ST_RX: begin
                        if (scl_rise && bitcnt < 4'd8) begin
                            shreg  <= {shreg[6:0], sda_lvl};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            case (ph)
                                PH_ADDR: begin
                                    if (addr_hit) begin
                                        sda_oe_o <= 1'b1;
                                        st       <= ST_RX_ACK;
                                        is_read  <= shreg[0];
                                        ph       <= shreg[0] ? PH_RD : PH_INDEX;
                                    end else begin
                                        st <= ST_IDLE;
                                    end
                                end
                                PH_INDEX: begin
                                    ptr      <= IDX_W'(shreg);
                                    ph       <= PH_COUNT;
                                    sda_oe_o <= 1'b1;
                                    st       <= ST_RX_ACK;
                                end
                                PH_COUNT: begin
                                    wleft    <= shreg;
                                    ph       <= PH_WDATA;
                                    sda_oe_o <= 1'b1;
                                    st       <= ST_RX_ACK;
                                end
                                PH_WDATA: begin
                                    sda_oe_o <= 1'b1;
                                    st       <= ST_RX_ACK;
                                    if (wleft != 8'd0) begin
                                        wr_en_o   <= 1'b1;
                                        wr_idx_o  <= ptr;
                                        wr_data_o <= shreg;
                                        ptr       <= ptr + IDX_W'(1);
                                        wleft     <= wleft - 8'd1;
                                    end
                                end
                                default: st <= ST_IDLE;
                            endcase
                        end
                    end
                    ST_RX_ACK: begin
                        if (scl_fall) begin
                            if (is_read && ph == PH_RD) begin
                                txsh     <= count_val;
                                sda_oe_o <= ~count_val[7];
                                bitcnt   <= '0;
                                st       <= ST_TX;
                            end else begin
                                sda_oe_o <= 1'b0;
                                st       <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                sda_oe_o <= 1'b0;
                                st       <= ST_TX_ACK;
                            end else begin
                                txsh     <= {txsh[6:0], 1'b0};
                                sda_oe_o <= ~txsh[6];
                                bitcnt   <= bitcnt + 4'd1;
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise && sda_lvl) begin
                            st <= ST_IDLE;
                        end else if (scl_fall) begin
                            txsh     <= rd_data;
                            sda_oe_o <= ~rd_data[7];
                            ptr      <= ptr + IDX_W'(1);
                            bitcnt   <= '0;
                            st       <= ST_TX;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R12: SDA drive is held steady across a whole SCL high phase.
    p_sda_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl)) |-> (sda_oe_o == $past(sda_oe_o)));

    // R11: the clock after a STOP leaves SDA released.
    p_stop_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_det) |-> !sda_oe_o);

    // R1: while ignoring the bus the target never pulls SDA.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && $past(st) == ST_IDLE) |-> !sda_oe_o);

    // R2: each committed write advances the pointer by exactly one.
    p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (ptr == wr_idx_o + IDX_W'(1)));

endmodule

// File: rtl/smb_cfg_target.sv
// Module: SMBus block-protocol configuration target (top).
// Joins the line synchronizer, protocol engine and register bank and
// forms the two mode selects, each forced by a 0 on the bit or the pin.
// Assumes: SDA is open-drain outside; sda_oe_o = 1 pulls it low.
module smb_cfg_target #(
    parameter int          NUM_REGS    = 22,
    parameter int          IDX_W       = 8,
    parameter int          STRAP_W     = 3,
    parameter int          SYNC_STAGES = 2,
    parameter logic [6:0]  ADDR_BASE   = 7'h68,
    parameter int          RB_FIRST    = 3,
    parameter int          RB_NUM      = 4,
    parameter int          ID_IDX      = 7,
    parameter int          CNT_IDX     = 8,
    parameter int          RSVD_FIRST  = 20,
    parameter int          ONES_LAST   = 2,
    parameter int          MODE_IDX    = 2,
    parameter int          BW_BIT      = 7,
    parameter int          BYP_BIT     = 6,
    parameter logic [7:0]  CNT_RST     = 8'h07,
    parameter logic [3:0]  REV_ID      = 4'h1,
    parameter logic [3:0]  VEN_ID      = 4'h1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    input  logic [STRAP_W-1:0]    addr_strap_i,
    input  logic                  bw_pin_i,
    input  logic                  byp_strap_i,
    input  logic [8*RB_NUM-1:0]   pin_rb_i,
    output logic [8*NUM_REGS-1:0] regs_o,
    output logic                  hi_bw_sel_o,
    output logic                  bypass_sel_o
);
    logic             scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [7:0]       wr_data, rd_data, count_val;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_cfg_link #(
        .STRAP_W   (STRAP_W),
        .IDX_W     (IDX_W),
        .ADDR_BASE (ADDR_BASE)
    ) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .strap_i   (addr_strap_i),
        .rd_data   (rd_data),
        .count_val (count_val),
        .sda_oe_o  (sda_oe_o),
        .wr_en_o   (wr_en),
        .wr_idx_o  (wr_idx),
        .wr_data_o (wr_data),
        .rd_idx_o  (rd_idx)
    );

    smb_cfg_bank #(
        .NREGS      (NUM_REGS),
        .IDX_W      (IDX_W),
        .RB_FIRST   (RB_FIRST),
        .RB_NUM     (RB_NUM),
        .ID_IDX     (ID_IDX),
        .CNT_IDX    (CNT_IDX),
        .RSVD_FIRST (RSVD_FIRST),
        .ONES_LAST  (ONES_LAST),
        .CNT_RST    (CNT_RST),
        .REV_ID     (REV_ID),
        .VEN_ID     (VEN_ID)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .pin_rb_i (pin_rb_i),
        .image_o  (regs_o),
        .count_o  (count_val)
    );

    // Mode selects: a 0 from either the control bit or the pin forces the mode.
    assign hi_bw_sel_o  = ~(regs_o[8*MODE_IDX + BW_BIT]  & bw_pin_i);
    assign bypass_sel_o = ~(regs_o[8*MODE_IDX + BYP_BIT] & byp_strap_i);

    // R8: pulling the bandwidth pin low always selects high bandwidth.
    p_bw_pin_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bw_pin_i) |-> hi_bw_sel_o);

    // R8: pulling the bypass strap low always selects bypass.
    p_byp_pin_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(byp_strap_i) |-> bypass_sel_o);

endmodule

// File: tb/smb_cfg_target_test.sv
module smb_cfg_target_test;
    localparam int Q  = 8;
    localparam int NR = 22;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [2:0]  strap = 3'b101;
    logic        bw_pin = 1'b1;
    logic        byp_pin = 1'b1;
    logic [31:0] pins = 32'hA55A_3C81;
    logic        sda_oe;
    logic        sda_bus;
    logic [8*NR-1:0] regs;
    logic        hi_bw, byp_sel;

    int n_chk = 0;
    int n_bad = 0;
    int r12_viol = 0;
    logic [7:0] mdl  [NR];
    logic [7:0] wbuf [32];
    logic [7:0] rbuf [32];
    logic       oe_after_nack;
    logic       scl_prev = 1'b1;
    logic       oe_prev  = 1'b0;

    assign sda_bus = sda_m & ~sda_oe;

    smb_cfg_target uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_bus),
        .sda_oe_o     (sda_oe),
        .addr_strap_i (strap),
        .bw_pin_i     (bw_pin),
        .byp_strap_i  (byp_pin),
        .pin_rb_i     (pins),
        .regs_o       (regs),
        .hi_bw_sel_o  (hi_bw),
        .bypass_sel_o (byp_sel)
    );

    always #2 clk = ~clk;

    // R12 monitor: SDA drive must not move while SCL stays high.
    always @(posedge clk) begin
        #1;
        if (rst_n && scl_m && scl_prev && (sda_oe != oe_prev)) r12_viol++;
        scl_prev = scl_m;
        oe_prev  = sda_oe;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=hung exp=done");
        finish_up();
    end

    // Expected model, computed from the requirements.
    function automatic bit writable(int idx);
        return (idx <= 2) || (idx >= 8 && idx <= 19);
    endfunction

    function automatic logic [7:0] exp_rd(int idx);
        if (idx >= 3 && idx <= 6) return pins[8*(idx-3) +: 8];
        if (idx == 7)             return 8'h11;
        if (idx < NR && writable(idx)) return mdl[idx];
        return 8'h00;
    endfunction

    task automatic model_wr(int idx, int cnt, int nsend);
        for (int i = 0; i < nsend && i < cnt; i++)
            if (writable(idx + i)) mdl[idx + i] = wbuf[i];
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic m_wbyte(input logic [7:0] b, output int ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(Q);
            scl_m = 1'b0;
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q/2);
        ack = (sda_bus == 1'b0) ? 1 : 0;
        tick(Q/2);
        scl_m = 1'b0;
    endtask

    task automatic m_rbyte(input logic nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(Q/2);
            b[i] = sda_bus;
            tick(Q/2);
            scl_m = 1'b0;
        end
        sda_m = nack; tick(Q);
        scl_m = 1'b1; tick(Q);
        scl_m = 1'b0;
        sda_m = 1'b1;
    endtask

    task automatic blk_write(input logic [7:0] wa, input int idx, input int cnt,
                             input int nsend, output int acks);
        int a;
        acks = 0;
        m_start();
        m_wbyte(wa, a);        acks += a;
        m_wbyte(8'(idx), a);   acks += a;
        m_wbyte(8'(cnt), a);   acks += a;
        for (int i = 0; i < nsend; i++) begin
            m_wbyte(wbuf[i], a); acks += a;
        end
        m_stop();
        tick(4);
    endtask

    task automatic blk_read(input logic [7:0] wa, input int idx, input int n,
                            output logic [7:0] cntb, output int acks);
        int a;
        acks = 0;
        m_start();
        m_wbyte(wa, a);        acks += a;
        m_wbyte(8'(idx), a);   acks += a;
        m_start();
        m_wbyte(wa | 8'h01, a); acks += a;
        m_rbyte(n == 0, cntb);
        for (int i = 0; i < n; i++) m_rbyte(i == n - 1, rbuf[i]);
        tick(6);
        oe_after_nack = sda_oe;
        m_stop();
        tick(4);
    endtask

    task automatic check_image(input string tag);
        for (int i = 0; i < NR; i++) chk(tag, int'(regs[8*i +: 8]), int'(exp_rd(i)));
    endtask

    initial begin
        int acks;
        logic [7:0] cb;
        logic [7:0] wa;
        void'($urandom(32'd4242));
        for (int i = 0; i < NR; i++) mdl[i] = (i <= 2) ? 8'hFF : (i == 8) ? 8'h07 : 8'h00;
        wa = 8'hDA;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R9 R7 R6: reset image on regs_o
        check_image("R9 reset image");
        chk("R8 reset hi_bw", int'(hi_bw), 0);
        chk("R8 reset bypass", int'(byp_sel), 0);
        chk("R11 reset sda idle", int'(sda_oe), 0);

        // R5 R6 R1 R4: read count and ID at strap 101 (0xDA/0xDB)
        blk_read(wa, 7, 2, cb, acks);
        chk("R1 acks on own address", acks, 3);
        chk("R5 count byte reset", int'(cb), 8'h07);
        chk("R6 id read", int'(rbuf[0]), 8'h11);
        chk("R5 count reg read", int'(rbuf[1]), 8'h07);
        chk("R4 sda released after nack", int'(oe_after_nack), 0);
        chk("R11 sda released after stop", int'(sda_oe), 0);

        // R2: directed block write of four bytes at 9
        wbuf[0] = 8'h12; wbuf[1] = 8'h34; wbuf[2] = 8'h56; wbuf[3] = 8'h78;
        blk_write(wa, 9, 4, 4, acks);
        model_wr(9, 4, 4);
        chk("R2 all bytes acked", acks, 7);
        check_image("R2 block write");

        // R3: bytes beyond count acked, not stored
        wbuf[0] = 8'hC1; wbuf[1] = 8'hC2; wbuf[2] = 8'hC3; wbuf[3] = 8'hC4;
        blk_write(wa, 12, 2, 4, acks);
        model_wr(12, 2, 4);
        chk("R3 overrun acked", acks, 7);
        chk("R3 idx14 untouched", int'(regs[8*14 +: 8]), 8'h00);
        chk("R3 idx13 stored", int'(regs[8*13 +: 8]), 8'hC2);

        // R1: wrong address gets no ACK and changes nothing
        wbuf[0] = 8'hEE;
        blk_write(8'hD0, 9, 1, 1, acks);
        chk("R1 foreign address nacked", acks, 0);
        chk("R1 foreign write ignored", int'(regs[8*9 +: 8]), 8'h12);
        // R1: strap 000 moves the address to 0xD0
        strap = 3'b000;
        tick(4);
        wbuf[0] = 8'h5D;
        blk_write(8'hD0, 10, 1, 1, acks);
        model_wr(10, 1, 1);
        chk("R1 strap 000 acks", acks, 4);
        chk("R1 strap 000 write", int'(regs[8*10 +: 8]), 8'h5D);
        strap = 3'b101;
        tick(4);

        // R6 R7: writes to readback and ID indexes do nothing
        for (int i = 0; i < 5; i++) wbuf[i] = 8'h00;
        blk_write(wa, 3, 5, 5, acks);
        chk("R7 readback write acked", acks, 8);
        blk_read(wa, 3, 5, cb, acks);
        for (int i = 0; i < 5; i++) chk("R7 R6 read-only after write", int'(rbuf[i]), int'(exp_rd(3 + i)));
        pins = 32'h0F1E_2D3C;
        tick(4);
        blk_read(wa, 4, 1, cb, acks);
        chk("R7 live pin readback", int'(rbuf[0]), 8'h2D);

        // R10: reserved and absent indexes
        for (int i = 0; i < 6; i++) wbuf[i] = 8'hA0 + 8'(i);
        blk_write(wa, 19, 6, 6, acks);
        model_wr(19, 6, 6);
        chk("R10 reserved write acked", acks, 9);
        blk_read(wa, 19, 6, cb, acks);
        chk("R10 idx19 stored", int'(rbuf[0]), 8'hA0);
        for (int i = 1; i < 6; i++) chk("R10 reserved reads zero", int'(rbuf[i]), 0);

        // R5: count register write changes the count byte
        wbuf[0] = 8'h03;
        blk_write(wa, 8, 1, 1, acks);
        model_wr(8, 1, 1);
        blk_read(wa, 0, 3, cb, acks);
        chk("R5 new count byte", int'(cb), 8'h03);
        chk("R4 read from 0", int'(rbuf[0]), 8'hFF);

        // R8: mode selects
        wbuf[0] = 8'h7F;
        blk_write(wa, 2, 1, 1, acks);
        model_wr(2, 1, 1);
        chk("R8 bit7 low forces hi_bw", int'(hi_bw), 1);
        chk("R8 bit6 high no bypass", int'(byp_sel), 0);
        wbuf[0] = 8'hBF;
        blk_write(wa, 2, 1, 1, acks);
        model_wr(2, 1, 1);
        chk("R8 bit7 high hi_bw off", int'(hi_bw), 0);
        chk("R8 bit6 low forces bypass", int'(byp_sel), 1);
        wbuf[0] = 8'hFF;
        blk_write(wa, 2, 1, 1, acks);
        model_wr(2, 1, 1);
        bw_pin = 1'b0; byp_pin = 1'b0;
        tick(3);
        chk("R8 pin forces hi_bw", int'(hi_bw), 1);
        chk("R8 strap forces bypass", int'(byp_sel), 1);
        bw_pin = 1'b1; byp_pin = 1'b1;
        tick(3);
        chk("R8 both high hi_bw off", int'(hi_bw), 0);

        // R11: STOP aborts mid-transfer, stored bytes kept
        begin
            int a;
            m_start();
            m_wbyte(wa, a);
            m_wbyte(8'd15, a);
            m_wbyte(8'd3, a);
            m_wbyte(8'h99, a);
            m_stop();
            tick(4);
        end
        mdl[15] = 8'h99;
        chk("R11 aborted write keeps byte", int'(regs[8*15 +: 8]), 8'h99);
        chk("R11 aborted write stops", int'(regs[8*16 +: 8]), 8'h00);
        chk("R11 sda idle after abort", int'(sda_oe), 0);

        // R2 R4: constrained random block writes, full readback
        for (int it = 0; it < 6; it++) begin
            int idx, cnt, ns;
            idx = int'($urandom_range(0, 23));
            cnt = int'($urandom_range(1, 4));
            ns  = cnt + int'($urandom_range(0, 1));
            for (int i = 0; i < ns; i++) wbuf[i] = 8'($urandom);
            if (idx <= 2 || (idx + cnt > 2 && idx <= 2)) wbuf[2 - ((idx <= 2) ? idx : 0)] = 8'hFF;
            blk_write(wa, idx, cnt, ns, acks);
            model_wr(idx, cnt, ns);
            chk("R2 random write acks", acks, 3 + ns);
            blk_read(wa, 0, NR, cb, acks);
            chk("R4 random count byte", int'(cb), int'(mdl[8]));
            for (int i = 0; i < NR; i++) chk("R4 random readback", int'(rbuf[i]), int'(exp_rd(i)));
        end
        check_image("R9 final image");

        chk("R12 sda steady while scl high", r12_viol, 0);
        finish_up();
    end
endmodule